// File: doc/BRIEF.md
# Configuration Register Unlock Sequencer

This block owns a one-byte configuration register that a serial slave front end reaches through transactions it has already decoded. Two bits of the register are volatile enable latches: a write-enable latch and a register-write-enable latch. The other five bits are retained fields: a two-bit watchdog period code and a three-bit block-protect code. The retained fields change only after a fixed three-step procedure. The first write arms the write-enable latch. The second arms the register-write-enable latch. The third write carries the new field values, and the stop condition that ends it commits them.

The front end presents start and stop strobes, a register-select flag, data bytes that carry a byte index within the transaction, and a read strobe. For each data byte the block answers with an acknowledge decision. While the modelled nonvolatile commit is in progress it raises a busy flag, and it shows the live register value at all times. A read returns a single byte. The actual storage is modelled as a retained register that only a cold-initialisation input reloads with factory values, together with a commit-delay counter.

Top module: `cfgreg_unlock_seq`

## Requirements
- R1: Register layout, bit 7 down to bit 0: constant 0, WD1, WD0, BP1, BP0, RWEL, WEL, BP2. Pulsing `cold_init` clears both latches, sets WD to 11 and BP to 000, so `reg_value` reads 0x60.
- R2: A synchronous active-low reset clears WEL, RWEL and busy. It leaves WD and BP untouched.
- R3: While WEL is 0, a data byte other than 0x02 is answered with NACK and changes nothing. A 0x02 byte is answered with ACK. When WEL is 1, every first data byte is answered with ACK unless busy is high.
- R4: A write of 0x02 while WEL is 0 sets WEL when the stop arrives and does not raise busy.
- R5: A write of 0x06 while WEL is 1 and RWEL is 0 sets RWEL. Any other byte in that state, except 0x00 and 0x02, changes nothing.
- R6: While WEL and RWEL are both 1, a byte with bit7=0, bit2=0 and bit1=1 commits at the stop. WD1 and WD0 are loaded from byte bits 6:5, BP1 and BP0 from bits 4:3, and BP2 from bit 0. RWEL is cleared, WEL stays 1, and busy is high for exactly COMMIT_CYCLES cycles.
- R7: While WEL and RWEL are both 1, a byte with bit2=1 and bit1=1 changes nothing, so RWEL stays 1. Any other byte that is not a commit pattern also changes nothing.
- R8: A write of 0x00 while WEL is 1 and RWEL is 0 clears WEL.
- R9: A data byte whose byte index is not 0 is answered with NACK and cancels the pending write, so the stop changes nothing.
- R10: While busy is high, every data byte is answered with NACK and the register does not change.
- R11: A read strobe with byte index 0 returns `reg_value` on `rd_data`, with `rd_valid` high on the next cycle. A read strobe with a nonzero index produces no `rd_valid`. Reads change neither the latches nor the unlock progress.
- R12: The register updates only at the clock edge of the stop that ends an accepted write. Between the data byte and the stop it holds its previous value.
- R13: The write sequence 0x02, 0x06, 0x02 leaves all retained fields at 0. The sequence 0x02, 0x06, 0x06 leaves them unchanged, with RWEL still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (volatile state only) |
| cold_init | input | 1 | Simulated cold initialisation, loads the factory field values |
| txn_start | input | 1 | Start condition strobe |
| txn_stop | input | 1 | Stop condition strobe |
| reg_sel | input | 1 | Transaction addresses this register |
| data_valid | input | 1 | Write data byte strobe |
| data_byte | input | 8 | Write data byte |
| byte_idx | input | IDX_W | Index of the byte within the transaction |
| rd_strobe | input | 1 | Register read request |
| ack_valid | output | 1 | An acknowledge decision is presented |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Commit in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data byte |
| reg_value | output | 8 | Live register value |

## Verification
A read and a committing stop can land in the same clock cycle. In that case the read samples the register at the same edge where the stop loads the new fields. The bench places `rd_strobe` in the cycle of the commit stop and requires two things: `rd_data` carries the value from before the commit, and `reg_value` already carries the committed value. A second overlap is a data byte that arrives while a commit is still counting down. The bench sends such a byte and checks that the byte is NACKed and the register stays unchanged. Every possible data byte is also swept from each of the three latch states, and each result is compared with arithmetic predictions.

// File: rtl/cfgreg_pkg.sv
// Package: shared constants and bit positions of the configuration register.
// Assumes: an 8-bit register whose layout is fixed by the decode of the unlock steps.
package cfgreg_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_BP2    = 0;
    localparam int BIT_WEL    = 1;
    localparam int BIT_RWEL   = 2;
    localparam logic [7:0] CMD_ARM_WEL  = 8'h02;
    localparam logic [7:0] CMD_ARM_RWEL = 8'h06;
    localparam logic [7:0] CMD_DISARM   = 8'h00;
    localparam logic [1:0] WD_FACTORY   = 2'b11;
    localparam logic [2:0] BP_FACTORY   = 3'b000;

    typedef struct packed {
        logic [1:0] wd;
        logic [2:0] bp;
    } retained_t;

    // Assemble the register image from its fields.
    function automatic logic [7:0] pack_reg(retained_t f, logic rwel, logic wel);
        return {1'b0, f.wd, f.bp[1:0], rwel, wel, f.bp[2]};
    endfunction
endpackage

// File: rtl/cfgreg_txn_track.sv
// Module: tracks one register write transaction and decides ACK/NACK per data byte.
// Assumes: the front end delivers start/stop/data strobes as single-cycle pulses.
module cfgreg_txn_track #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_stop,
    input  logic             reg_sel,
    input  logic             data_valid,
    input  logic [7:0]       data_byte,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             wel,
    input  logic             busy,
    output logic             ack_valid,
    output logic             ack,
    output logic             wr_fire,
    output logic [7:0]       wr_byte
);
    import cfgreg_pkg::*;

    logic pend_q;
    logic [7:0] pend_byte_q;
    logic extra_byte;
    logic accept;

    // A byte counts as extra if it is not first or if one is already pending.
    assign extra_byte = (byte_idx != '0) || pend_q;
    // Acceptance rule for a data byte.
    assign accept = !extra_byte && !busy && (wel || data_byte == CMD_ARM_WEL);

    // Hold the pending byte and emit the acknowledge decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_byte_q <= '0;
            ack_valid   <= 1'b0;
            ack         <= 1'b0;
        end else begin
            ack_valid <= data_valid && reg_sel;
            if (txn_start) begin
                pend_q <= 1'b0;
            end
            if (data_valid && reg_sel) begin
                ack <= accept;
                if (accept) begin
                    pend_q      <= 1'b1;
                    pend_byte_q <= data_byte;
                end else if (extra_byte) begin
                    pend_q <= 1'b0;
                end
            end
            if (txn_stop) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign wr_fire = txn_stop && pend_q;
    assign wr_byte = pend_byte_q;

    p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && reg_sel && busy) |=> (ack_valid && !ack));
    p_extra_byte_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && reg_sel && byte_idx != '0) |=> (ack_valid && !ack));
endmodule

// File: rtl/cfgreg_commit_timer.sv
// Module: models the nonvolatile commit delay as a down-counter.
// Assumes: a commit is never requested while a previous one is counting.
module cfgreg_commit_timer #(
    parameter int COMMIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_init,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on commit, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_init) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    p_start_loads_r6: assert property (@(posedge clk) disable iff (!rst_n || cold_init)
        start |=> (cnt_q == LOAD));
endmodule

// File: rtl/cfgreg_field_store.sv
// Module: holds the enable latches and retained fields, decodes the unlock steps.
// Assumes: wr_fire is a one-cycle pulse at the stop of an accepted write.
module cfgreg_field_store (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cold_init,
    input  logic       wr_fire,
    input  logic [7:0] wr_byte,
    output logic       wel,
    output logic       commit,
    output logic [7:0] reg_value
);
    import cfgreg_pkg::*;

    logic wel_q, rwel_q;
    retained_t fields_q;
    logic set_wel, set_rwel, clr_wel, commit_pat;

    // Decode of the written byte against the current latch state.
    always_comb begin
        set_wel    = !wel_q && wr_byte == CMD_ARM_WEL;
        set_rwel   = wel_q && !rwel_q && wr_byte == CMD_ARM_RWEL;
        clr_wel    = wel_q && !rwel_q && wr_byte == CMD_DISARM;
        commit_pat = wel_q && rwel_q && !wr_byte[7] && !wr_byte[BIT_RWEL] && wr_byte[BIT_WEL];
    end

    assign commit = wr_fire && commit_pat;

    // Volatile latches: cleared by reset or cold init, stepped by accepted writes.
    always_ff @(posedge clk) begin
        if (cold_init || !rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (wr_fire) begin
            if (set_wel)    wel_q  <= 1'b1;
            if (clr_wel)    wel_q  <= 1'b0;
            if (set_rwel)   rwel_q <= 1'b1;
            if (commit_pat) rwel_q <= 1'b0;
        end
    end

    // Retained fields: factory load on cold init only, otherwise loaded on commit.
    always_ff @(posedge clk) begin
        if (cold_init) begin
            fields_q.wd <= WD_FACTORY;
            fields_q.bp <= BP_FACTORY;
        end else if (rst_n && commit) begin
            fields_q.wd <= wr_byte[6:5];
            fields_q.bp <= {wr_byte[BIT_BP2], wr_byte[4:3]};
        end
    end

    assign wel       = wel_q;
    assign reg_value = pack_reg(fields_q, rwel_q, wel_q);

    p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n || cold_init)
        $rose(rwel_q) |-> $past(wel_q));
    p_fields_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cold_init && !wr_fire) |=> $stable(fields_q));
    p_commit_clears_rwel_r6: assert property (@(posedge clk) disable iff (!rst_n || cold_init)
        commit |=> (!rwel_q && wel_q));
endmodule

// File: rtl/cfgreg_unlock_seq.sv
// Module: top of the configuration register with its three-step write unlock.
// Assumes: bus decoding is done upstream; cold_init is asserted once before use.
module cfgreg_unlock_seq #(
    parameter int IDX_W         = 4,
    parameter int COMMIT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_init,
    input  logic             txn_start,
    input  logic             txn_stop,
    input  logic             reg_sel,
    input  logic             data_valid,
    input  logic [7:0]       data_byte,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             rd_strobe,
    output logic             ack_valid,
    output logic             ack,
    output logic             busy,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [7:0]       reg_value
);
    logic       wel;
    logic       wr_fire;
    logic [7:0] wr_byte;
    logic       commit;

    cfgreg_txn_track #(.IDX_W(IDX_W)) u_txn (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .reg_sel(reg_sel), .data_valid(data_valid), .data_byte(data_byte),
        .byte_idx(byte_idx), .wel(wel), .busy(busy), .ack_valid(ack_valid),
        .ack(ack), .wr_fire(wr_fire), .wr_byte(wr_byte)
    );

    cfgreg_field_store u_store (
        .clk(clk), .rst_n(rst_n), .cold_init(cold_init), .wr_fire(wr_fire),
        .wr_byte(wr_byte), .wel(wel), .commit(commit), .reg_value(reg_value)
    );

    cfgreg_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .cold_init(cold_init), .start(commit), .busy(busy)
    );

    // Single-byte read port: only the first byte index returns data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_strobe && reg_sel && byte_idx == '0;
            if (rd_strobe && reg_sel && byte_idx == '0) begin
                rd_data <= reg_value;
            end
        end
    end

    p_single_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && byte_idx != '0) |=> !rd_valid);
    p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n || cold_init)
        commit |=> busy);
    p_bit7_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_value[7]);
endmodule

// File: tb/tb_cfgreg_unlock_seq.sv
// Bench: sweeps every data byte from each latch state, plus directed corner cases.
module tb_cfgreg_unlock_seq;
    localparam int IDX_W = 4;
    localparam int NCYC  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cold_init = 1'b0, txn_start = 1'b0, txn_stop = 1'b0;
    logic reg_sel = 1'b0, data_valid = 1'b0, rd_strobe = 1'b0;
    logic [7:0] data_byte = '0;
    logic [IDX_W-1:0] byte_idx = '0;
    logic ack_valid, ack, busy, rd_valid;
    logic [7:0] rd_data, reg_value;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_reg;
    logic a0, a1;

    always #5 clk = ~clk;

    cfgreg_unlock_seq #(.IDX_W(IDX_W), .COMMIT_CYCLES(NCYC)) dut (
        .clk(clk), .rst_n(rst_n), .cold_init(cold_init), .txn_start(txn_start),
        .txn_stop(txn_stop), .reg_sel(reg_sel), .data_valid(data_valid),
        .data_byte(data_byte), .byte_idx(byte_idx), .rd_strobe(rd_strobe),
        .ack_valid(ack_valid), .ack(ack), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .reg_value(reg_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected register after an accepted write, from the requirement rules.
    function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [7:0] d);
        if (!cur[1]) return (d == 8'h02) ? (cur | 8'h02) : cur;
        if (!cur[2]) begin
            if (d == 8'h06) return cur | 8'h04;
            if (d == 8'h00) return cur & ~8'h02;
            return cur;
        end
        if (!d[7] && !d[2] && d[1]) return {1'b0, d[6:3], 1'b0, 1'b1, d[0]};
        return cur;
    endfunction

    function automatic logic model_commit(input logic [7:0] cur, input logic [7:0] d);
        return cur[1] && cur[2] && !d[7] && !d[2] && d[1];
    endfunction

    // One register write transaction; optional second byte; returns both ACKs.
    task automatic wr(input logic [7:0] d, input bit two, output logic ack0, output logic ack1);
        @(negedge clk) txn_start = 1'b1; reg_sel = 1'b1;
        @(negedge clk) txn_start = 1'b0; data_valid = 1'b1; data_byte = d; byte_idx = '0;
        @(negedge clk) data_valid = 1'b0; ack0 = ack_valid && ack;
        ack1 = 1'b0;
        if (two) begin
            data_valid = 1'b1; byte_idx = 1;
            @(negedge clk) data_valid = 1'b0; byte_idx = '0; ack1 = ack_valid && ack;
        end
        txn_stop = 1'b1;
        @(negedge clk) txn_stop = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        exp_reg = exp_reg & ~8'h06;
    endtask

    // Write with model update and per-byte checks.
    task automatic wr_chk(input logic [7:0] d, input string req);
        logic cm;
        cm = model_commit(exp_reg, d);
        wr(d, 1'b0, a0, a1);
        check({req, " ack"}, a0, exp_reg[1] || d == 8'h02);
        exp_reg = model_next(exp_reg, d);
        check({req, " reg"}, reg_value, exp_reg);
        check({req, " busy"}, busy, cm);
        wait_idle();
    endtask

    initial begin
        int bcnt;
        // R1: cold initialisation gives factory image 0x60
        @(negedge clk) cold_init = 1'b1;
        @(negedge clk) cold_init = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R1 factory value", reg_value, 8'h60);
        check("R2 busy idle", busy, 0);
        exp_reg = 8'h60;

        // R3 R4 R5 R6 R7 R8: every byte from each latch state
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 256; d++) begin
                do_reset();
                check("R2 latches cleared", reg_value, exp_reg);
                if (s >= 1) wr_chk(8'h02, "R4");
                if (s >= 2) wr_chk(8'h06, "R5");
                wr_chk(8'(d), s == 0 ? "R3" : (s == 1 ? "R5/R8" : "R6/R7"));
            end
        end

        // R13: 02,06,02 clears retained fields; 02,06,06 keeps them with RWEL set
        do_reset();
        wr_chk(8'h02, "R13"); wr_chk(8'h06, "R13"); wr_chk(8'h7B, "R13 setup");
        do_reset();
        wr_chk(8'h02, "R13"); wr_chk(8'h06, "R13"); wr_chk(8'h02, "R13");
        check("R13 fields zero", reg_value, 8'h02);
        do_reset();
        wr_chk(8'h02, "R13"); wr_chk(8'h06, "R13"); wr_chk(8'h06, "R13");
        check("R13 rwel kept", reg_value, 8'h06);

        // R6: busy length equals COMMIT_CYCLES; R2: reset keeps fields
        do_reset();
        wr_chk(8'h02, "R6"); wr_chk(8'h06, "R6");
        wr(8'h2B, 1'b0, a0, a1);
        bcnt = 0;
        while (busy && bcnt < 1000) begin bcnt++; @(negedge clk); end
        check("R6 busy length", bcnt, NCYC);
        check("R6 committed", reg_value, 8'h2B & 8'h7B | 8'h02);
        exp_reg = reg_value;
        do_reset();
        check("R2 fields kept", reg_value, 8'h29);
        exp_reg = 8'h29;

        // R10: writes during busy are NACKed and ignored
        wr_chk(8'h02, "R10"); wr_chk(8'h06, "R10");
        wr(8'h42, 1'b0, a0, a1);
        exp_reg = 8'h42;
        check("R10 busy", busy, 1);
        wr(8'h00, 1'b0, a0, a1);
        check("R10 nack", a0, 0);
        check("R10 unchanged", reg_value, exp_reg);
        wait_idle();

        // R9: a second byte is NACKed and cancels the write
        wr(8'h00, 1'b1, a0, a1);
        check("R9 first ack", a0, 1);
        check("R9 second nack", a1, 0);
        check("R9 no change", reg_value, exp_reg);

        // R12: register holds between data byte and stop
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0; data_valid = 1'b1; data_byte = 8'h06;
        @(negedge clk) data_valid = 1'b0;
        @(negedge clk);
        check("R12 held before stop", reg_value, exp_reg);
        txn_stop = 1'b1;
        @(negedge clk) txn_stop = 1'b0;
        exp_reg = exp_reg | 8'h04;
        check("R12 updated at stop", reg_value, exp_reg);

        // R11: reads return one byte and leave the unlock progress intact
        @(negedge clk) rd_strobe = 1'b1; byte_idx = '0;
        @(negedge clk) rd_strobe = 1'b0;
        check("R11 rd_valid", rd_valid, 1);
        check("R11 rd_data", rd_data, exp_reg);
        rd_strobe = 1'b1; byte_idx = 1;
        @(negedge clk) rd_strobe = 1'b0; byte_idx = '0;
        check("R11 no second byte", rd_valid, 0);

        // R11 R6: read in the same cycle as the committing stop
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0; data_valid = 1'b1; data_byte = 8'h1A;
        @(negedge clk) data_valid = 1'b0;
        txn_stop = 1'b1; rd_strobe = 1'b1;
        @(negedge clk) txn_stop = 1'b0; rd_strobe = 1'b0;
        check("R11 read sees pre-commit", rd_data, exp_reg);
        check("R6 commit after read", reg_value, 8'h1A);
        wait_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule